// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block sits beside a CPU bus sequencer and decides, for every bus cycle, how many wait clocks are added before the cycle may finish. The sequencer presents a cycle descriptor with a valid/ready handshake: the cycle kind, the level of the opcode-fetch (first machine cycle) strobe, and the I/O address. The block latches a wait count for that cycle from a small configuration register and fixed per-kind rules. It then raises a wait-insert output once per clock until the count runs out. An external wait request, or a synchronisation hint from on-chip data registers, can lengthen the wait phase. A one-clock done strobe closes the wait phase.

The configuration register holds two 2-bit fields, one for memory cycles and one for I/O cycles. Software writes it through a simple write-enable port and can read it back at any time. Reset loads all ones into both fields, which selects the longest waits. Handshake rules: `req_ready` is high only while no cycle is in progress. A descriptor is taken on a clock edge where `req_valid` and `req_ready` are both high. The sequencer may hold `req_valid` high for as long as it likes, and it has no effect while `req_ready` is low. The cycle finishes on the clock where `cyc_done` is high, and `req_ready` returns on the following clock.

Top module: `bus_wait_gen`

## Requirements
- R1: After reset `cfg_rdata` reads 4'hF (both fields all ones), `req_ready` is high, and `wait_ins` and `cyc_done` are low. With no write, a memory cycle then takes 3 waits and an external I/O cycle takes 4.
- R2: The register layout is bits [1:0] for the memory field and bits [3:2] for the I/O field. A memory cycle (kind 3'd0) inserts 0, 1, 2 or 3 waits for memory field values 0, 1, 2 or 3.
- R3: An I/O cycle (kind 3'd1) whose address is 0x0040 or above inserts (I/O field + 1) waits, so field values 0 to 3 give 1 to 4 waits.
- R4: An acknowledge cycle of the level-0 external interrupt (kind 3'd2) with `fetch_cyc` high inserts 2, 4, 5 or 6 waits for I/O field values 0, 1, 2 or 3.
- R5: An acknowledge cycle of the level-1 or level-2 external interrupt or of an internal interrupt (kind 3'd3) with `fetch_cyc` high always inserts 2 waits, whatever either field holds.
- R6: A non-maskable interrupt acknowledge (kind 3'd4) with `fetch_cyc` high inserts 0 waits.
- R7: Any acknowledge kind (3'd2 to 3'd4) with `fetch_cyc` low uses memory-cycle timing from the memory field.
- R8: An I/O cycle at an address below 0x0040 whose map bit is clear (for example 0x0034) is an on-chip control access. It inserts 0 waits whatever the I/O field holds and whatever `ext_wait` does.
- R9: An I/O cycle at an on-chip data address (0x0008 to 0x0013 by default) inserts one wait per clock while `sync_rdy` is low, and at most 4 waits. It ends on the first clock where `sync_rdy` is high.
- R10: For every kind except on-chip I/O, once the latched count has run out, each clock with `ext_wait` high adds one more wait.
- R11: `cyc_done` is high for exactly one clock per cycle and never together with `wait_ins`. `req_ready` is low from the clock after acceptance until the clock after `cyc_done`.
- R12: The wait count is fixed when the cycle is accepted. A register write made during a cycle changes only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the wait configuration register |
| cfg_wdata | input | 4 | Write data: [1:0] memory field, [3:2] I/O field |
| cfg_rdata | output | 4 | Current register contents |
| req_valid | input | 1 | Cycle descriptor valid |
| req_ready | output | 1 | Block idle, able to take a descriptor |
| req_kind | input | 3 | Cycle kind: 0 mem, 1 I/O, 2 ack level 0, 3 ack level 1/2/internal, 4 ack NMI |
| fetch_cyc | input | 1 | High when the opcode-fetch strobe is asserted for this cycle |
| req_addr | input | 16 | I/O address |
| sync_rdy | input | 1 | Ready hint from on-chip data registers |
| ext_wait | input | 1 | External wait request, active high |
| wait_ins | output | 1 | Insert a wait state this clock |
| cyc_done | output | 1 | Wait phase over, cycle finishes this clock |

## Verification
The hardest situations to reach from the ports are the cycles whose length does not depend on the latched count alone. One is an on-chip data access that `sync_rdy` releases part-way through its window. Another is a register write that lands in the middle of a cycle. The bench drives `sync_rdy` and `ext_wait` from inside its cycle-counting task, changing them just after the clock edge once a set number of waits has been seen. It also runs a configuration write in parallel with a long memory cycle, so that the write is accepted while the wait phase is still running.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  typedef enum logic [2:0] {
    KIND_MEM    = 3'd0,
    KIND_IO     = 3'd1,
    KIND_ACK_L0 = 3'd2,
    KIND_ACK_LX = 3'd3,
    KIND_ACK_NM = 3'd4
  } cyc_kind_e;

  localparam int FIELD_W = 2;
  localparam int CFG_W   = 2 * FIELD_W;

  typedef struct packed {
    logic [FIELD_W-1:0] io_fld;
    logic [FIELD_W-1:0] mem_fld;
  } wait_cfg_t;
endpackage

// File: rtl/bwg_cfg_reg.sv
module bwg_cfg_reg
  import bwg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output wait_cfg_t        cfg
);
  wait_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '1;
    end else if (we) begin
      cfg_q <= wait_cfg_t'(wdata);
    end
  end

  assign cfg   = cfg_q;
  assign rdata = CFG_W'(cfg_q);
endmodule

// File: rtl/bwg_count_sel.sv
module bwg_count_sel
  import bwg_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          ONCHIP_SPAN  = 64,
  parameter logic [63:0] DATA_REG_MAP = 64'h0000_0000_000F_FF00,
  parameter int          CNT_W        = 3,
  parameter int          SYNC_MAX     = 4
) (
  input  wait_cfg_t         cfg,
  input  logic [2:0]        kind,
  input  logic              fetch,
  input  logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              sync_mode,
  output logic              ext_ok
);
  localparam int SPAN_BITS = $clog2(ONCHIP_SPAN);

  logic                 onchip;
  logic                 data_reg;
  logic [CNT_W-1:0]     mem_cnt;
  logic [CNT_W-1:0]     l0_cnt;

  assign onchip   = (addr >> SPAN_BITS) == '0;
  assign data_reg = onchip && DATA_REG_MAP[addr[SPAN_BITS-1:0]];
  assign mem_cnt  = CNT_W'(cfg.mem_fld);

  always_comb begin
    unique case (cfg.io_fld)
      2'd0:    l0_cnt = CNT_W'(2);
      2'd1:    l0_cnt = CNT_W'(4);
      2'd2:    l0_cnt = CNT_W'(5);
      default: l0_cnt = CNT_W'(6);
    endcase
  end

  always_comb begin
    cnt       = mem_cnt;
    sync_mode = 1'b0;
    ext_ok    = 1'b1;
    case (kind)
      KIND_MEM: cnt = mem_cnt;
      KIND_IO: begin
        if (data_reg) begin
          cnt       = CNT_W'(SYNC_MAX);
          sync_mode = 1'b1;
          ext_ok    = 1'b0;
        end else if (onchip) begin
          cnt    = '0;
          ext_ok = 1'b0;
        end else begin
          cnt = CNT_W'(cfg.io_fld) + CNT_W'(1);
        end
      end
      KIND_ACK_L0: cnt = fetch ? l0_cnt : mem_cnt;
      KIND_ACK_LX: cnt = fetch ? CNT_W'(2) : mem_cnt;
      KIND_ACK_NM: cnt = fetch ? '0 : mem_cnt;
      default:     cnt = mem_cnt;
    endcase
  end
endmodule

// File: rtl/bwg_wait_fsm.sv
module bwg_wait_fsm #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             sync_in,
  input  logic             ext_ok_in,
  input  logic             sync_rdy,
  input  logic             ext_wait,
  output logic             busy,
  output logic             wait_ins,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             sync_q;
  logic             ext_ok_q;
  logic             cnt_live;
  logic             step;

  assign cnt_live = cnt_q != '0;
  assign step     = cnt_live && (!sync_q || !sync_rdy);

  always_comb begin
    if (!busy)         wait_ins = 1'b0;
    else if (cnt_live) wait_ins = sync_q ? !sync_rdy : 1'b1;
    else               wait_ins = ext_ok_q && ext_wait;
  end

  assign done = busy && !wait_ins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      sync_q   <= 1'b0;
      ext_ok_q <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        cnt_q    <= cnt_in;
        sync_q   <= sync_in;
        ext_ok_q <= ext_ok_in;
      end
    end else if (done) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import bwg_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          ONCHIP_SPAN  = 64,
  parameter logic [63:0] DATA_REG_MAP = 64'h0000_0000_000F_FF00,
  parameter int          SYNC_MAX     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_wdata,
  output logic [3:0]        cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic              fetch_cyc,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              sync_rdy,
  input  logic              ext_wait,
  output logic              wait_ins,
  output logic              cyc_done
);
  localparam int MAX_WAIT = (SYNC_MAX > 6) ? SYNC_MAX : 6;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  wait_cfg_t        cfg;
  logic [CNT_W-1:0] sel_cnt;
  logic             sel_sync;
  logic             sel_ext;
  logic             busy;

  bwg_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  bwg_count_sel #(
    .ADDR_W       (ADDR_W),
    .ONCHIP_SPAN  (ONCHIP_SPAN),
    .DATA_REG_MAP (DATA_REG_MAP),
    .CNT_W        (CNT_W),
    .SYNC_MAX     (SYNC_MAX)
  ) u_sel (
    .cfg       (cfg),
    .kind      (req_kind),
    .fetch     (fetch_cyc),
    .addr      (req_addr),
    .cnt       (sel_cnt),
    .sync_mode (sel_sync),
    .ext_ok    (sel_ext)
  );

  bwg_wait_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (req_valid),
    .cnt_in    (sel_cnt),
    .sync_in   (sel_sync),
    .ext_ok_in (sel_ext),
    .sync_rdy  (sync_rdy),
    .ext_wait  (ext_wait),
    .busy      (busy),
    .wait_ins  (wait_ins),
    .done      (cyc_done)
  );

  assign req_ready = !busy;
endmodule

// File: rtl/bus_wait_gen_chk.sv
module bus_wait_gen_chk #(
  parameter int          ADDR_W       = 16,
  parameter int          ONCHIP_SPAN  = 64,
  parameter logic [63:0] DATA_REG_MAP = 64'h0000_0000_000F_FF00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cfg_rdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_kind,
  input logic              fetch_cyc,
  input logic [ADDR_W-1:0] req_addr,
  input logic              ext_wait,
  input logic              wait_ins,
  input logic              cyc_done
);
  localparam int SB = $clog2(ONCHIP_SPAN);

  logic accept;
  logic ctrl_hit;

  assign accept   = req_valid && req_ready;
  assign ctrl_hit = ((req_addr >> SB) == '0) && !DATA_REG_MAP[req_addr[SB-1:0]];

  AST_RESET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_rdata == 4'hF && req_ready)); // R1

  AST_NMI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == 3'd4 && fetch_cyc) |=> (!wait_ins || ext_wait)); // R6

  AST_CTRL_NOWAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == 3'd1 && ctrl_hit) |=> (cyc_done && !wait_ins)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> (!cyc_done && req_ready)); // R11

  AST_WAIT_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_ins && cyc_done)); // R11

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R11
endmodule

bind bus_wait_gen bus_wait_gen_chk #(
  .ADDR_W       (ADDR_W),
  .ONCHIP_SPAN  (ONCHIP_SPAN),
  .DATA_REG_MAP (DATA_REG_MAP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .fetch_cyc (fetch_cyc),
  .req_addr  (req_addr),
  .ext_wait  (ext_wait),
  .wait_ins  (wait_ins),
  .cyc_done  (cyc_done)
);

// File: tb/tb_bus_wait_gen.sv
module tb_bus_wait_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic [3:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic        fetch_cyc = 1'b0;
  logic [15:0] req_addr = '0;
  logic        sync_rdy = 1'b1;
  logic        ext_wait = 1'b0;
  logic        wait_ins;
  logic        cyc_done;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_wait_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .fetch_cyc(fetch_cyc), .req_addr(req_addr),
    .sync_rdy(sync_rdy), .ext_wait(ext_wait), .wait_ins(wait_ins),
    .cyc_done(cyc_done)
  );

  // {cfg, kind, fetch, addr, expected waits, sync release, tag}
  typedef struct packed {
    logic [3:0]  cfg;
    logic [2:0]  kind;
    logic        fetch;
    logic [15:0] addr;
    logic [7:0]  exp;
    logic [7:0]  rel;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{4'h0, 3'd0, 1'b0, 16'h0000, 8'd0, 8'd0, 8'd2},   // R2
    '{4'h2, 3'd0, 1'b0, 16'h0000, 8'd2, 8'd0, 8'd2},   // R2
    '{4'h3, 3'd0, 1'b0, 16'h0000, 8'd3, 8'd0, 8'd2},   // R2
    '{4'h0, 3'd1, 1'b0, 16'h0100, 8'd1, 8'd0, 8'd3},   // R3
    '{4'h4, 3'd1, 1'b0, 16'h0100, 8'd2, 8'd0, 8'd3},   // R3
    '{4'h8, 3'd1, 1'b0, 16'h8000, 8'd3, 8'd0, 8'd3},   // R3
    '{4'hC, 3'd1, 1'b0, 16'h0040, 8'd4, 8'd0, 8'd3},   // R3
    '{4'h0, 3'd2, 1'b1, 16'h0000, 8'd2, 8'd0, 8'd4},   // R4
    '{4'h4, 3'd2, 1'b1, 16'h0000, 8'd4, 8'd0, 8'd4},   // R4
    '{4'h8, 3'd2, 1'b1, 16'h0000, 8'd5, 8'd0, 8'd4},   // R4
    '{4'hF, 3'd2, 1'b1, 16'h0000, 8'd6, 8'd0, 8'd4},   // R4
    '{4'hF, 3'd3, 1'b1, 16'h0000, 8'd2, 8'd0, 8'd5},   // R5
    '{4'h0, 3'd3, 1'b1, 16'h0000, 8'd2, 8'd0, 8'd5},   // R5
    '{4'hF, 3'd4, 1'b1, 16'h0000, 8'd0, 8'd0, 8'd6},   // R6
    '{4'hD, 3'd2, 1'b0, 16'h0000, 8'd1, 8'd0, 8'd7},   // R7
    '{4'hF, 3'd1, 1'b0, 16'h0034, 8'd0, 8'd0, 8'd8},   // R8
    '{4'h0, 3'd1, 1'b0, 16'h0009, 8'd4, 8'd99, 8'd9}   // R9
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [3:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // Runs one bus cycle; returns the number of wait clocks seen.
  task automatic run_cyc(input logic [2:0] k, input logic f, input logic [15:0] a,
                         input int ext_n, input int rel, output int n);
    @(posedge clk); #1;
    req_valid = 1'b1; req_kind = k; fetch_cyc = f; req_addr = a;
    ext_wait  = (ext_n > 0);
    sync_rdy  = (rel == 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (cyc_done) break;
      if (wait_ins) n++;
      @(posedge clk); #1;
      if (n >= ext_n) ext_wait = 1'b0;
      if (n >= rel)   sync_rdy = 1'b1;
    end
    @(negedge clk);
    ext_wait = 1'b0;
    sync_rdy = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rdata in reset", int'(cfg_rdata), 15);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(req_ready), 1);
    check("R1 idle wait/done", int'({wait_ins, cyc_done}), 0);
    run_cyc(3'd0, 1'b0, 16'h0000, 0, 0, n);
    check("R1 default mem waits", n, 3);
    run_cyc(3'd1, 1'b0, 16'h0200, 0, 0, n);
    check("R1 default io waits", n, 4);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      write_cfg(VEC[i].cfg);
      @(negedge clk);
      check($sformatf("R2 readback v%0d", i), int'(cfg_rdata), int'(VEC[i].cfg));
      run_cyc(VEC[i].kind, VEC[i].fetch, VEC[i].addr, 0, int'(VEC[i].rel), n);
      check($sformatf("R%0d vec %0d", VEC[i].req, i), n, int'(VEC[i].exp));
    end

    // R8: control register ignores ext_wait
    write_cfg(4'hF);
    run_cyc(3'd1, 1'b0, 16'h0034, 5, 0, n);
    check("R8 ctrl ignores ext_wait", n, 0);

    // R9: sync release after 2 waits
    run_cyc(3'd1, 1'b0, 16'h0012, 0, 2, n);
    check("R9 sync release early", n, 2);
    run_cyc(3'd1, 1'b0, 16'h0008, 0, 0, n);
    check("R9 sync ready at start", n, 0);

    // R10: ext_wait extension past programmed count
    write_cfg(4'h0);
    run_cyc(3'd0, 1'b0, 16'h0000, 3, 0, n);
    check("R10 mem ext extension", n, 3);
    write_cfg(4'h1);
    run_cyc(3'd1, 1'b0, 16'h0100, 5, 0, n);
    check("R10 io ext extension", n, 5);

    // R11: done single pulse and ready back
    @(posedge clk); #1;
    req_valid = 1'b1; req_kind = 3'd4; fetch_cyc = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check("R11 busy after accept", int'(req_ready), 0);
    check("R11 done pulse", int'(cyc_done), 1);
    @(negedge clk);
    check("R11 done drops", int'(cyc_done), 0);
    check("R11 ready returns", int'(req_ready), 1);

    // R12: write during cycle affects next cycle only
    write_cfg(4'h3);
    fork
      run_cyc(3'd0, 1'b0, 16'h0000, 0, 0, n);
      begin
        @(posedge clk); #1;
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = 4'h0;
        @(posedge clk); #1;
        cfg_we = 1'b0;
      end
    join
    check("R12 in-flight count kept", n, 3);
    run_cyc(3'd0, 1'b0, 16'h0000, 0, 0, n);
    check("R12 next cycle uses write", n, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule